// File: doc/BRIEF.md
# Fault Response and Retry Controller

This block decides what a power channel does when one of its fault conditions becomes active. Each fault source has its own response byte. The top two bits of that byte pick the action, the middle three bits pick what happens after a shutdown, and the low three bits give a delay. The block combines these per-fault decisions into one channel state. Its outputs are a disable request for the power stage, a one-cycle start request when a retry fires, and a level that drives the open-drain fault pin.

The block also watches the RUN line. When RUN falls, the block holds RUN low for a programmed number of timebase ticks, so the channel cannot restart sooner than the minimum off time. The recommended setting is one that equals at least 136 ms. An internal prescaler divides the clock into these ticks. All delays, retry intervals and restart holds are counted in ticks.

Response bytes are written through a simple write strobe. The block rejects an encoding it does not support and flags the attempt as a communication/logic fault. Fault sensing and status storage live outside the block. The block only reports a one-cycle hit pulse when each fault rises.

Top module: `fault_retry_ctrl`

## Requirements
- R1: After reset, every response byte is 0x00. `dis_req` is 1. `run_pull_low`, `fault_pin`, `start_req`, `cfg_reject` and `fault_hit` are 0.
- R2: With `run_in` and `op_on` both high and no RUN hold active, the channel enters the running state on the next clock edge, and `dis_req` drops to 0.
- R3: Response bits [7:6] = 00 (ignore): an active fault does not change `dis_req` or `fault_pin`.
- R4: Bits [7:6] = 10 (stop now) with retry bits [5:3] = 000 (latch off): `dis_req` and `fault_pin` go to 1 on the edge after the fault is seen. They stay there after the fault clears, until `run_in` or `op_on` goes low and then high again.
- R5: Retry bits [5:3] = 111 (retry forever): after a shutdown the channel waits `retry_ticks` ticks. It then gives a one-cycle `start_req`, returns to running with `fault_pin` low, and repeats this cycle as long as the fault persists.
- R6: Bits [7:6] = 01 (run on, then stop): shutdown happens once the fault has stayed active for the number of ticks in bits [2:0].
- R7: If the fault clears before that delay expires, the shutdown is cancelled and the delay count starts again from zero.
- R8: A write is rejected when it is out of range or illegal. Illegal means: bits [7:6] = 11 on a non-shared fault, retry bits other than 000 or 111, or a shared-fault byte other than 0x00 or 0xC0. A rejected write gives a one-cycle `cfg_reject` on the edge after the write and leaves the stored byte unchanged.
- R9: A falling edge on `run_in` sets `run_pull_low` for `restart_ticks` ticks. The channel stays disabled until that hold ends.
- R10: Fault 0 is the shared fault input. With response 0xC0, `dis_req` follows its level and `fault_pin` and the channel state are unaffected. With 0x00 it is ignored.
- R11: Each rising edge of `fault_evt[i]` gives a one-cycle `fault_hit[i]` pulse one edge later, whatever the response byte.
- R12: When several faults trip in the same cycle, the lowest-numbered one selects the retry behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Response byte write strobe |
| cfg_sel | input | $clog2(NUM_FAULTS) | Fault index being written |
| cfg_data | input | 8 | Response byte value |
| cfg_reject | output | 1 | Pulse: write rejected (communication/logic fault) |
| run_in | input | 1 | Sensed level of the RUN line |
| op_on | input | 1 | On/off command level |
| fault_evt | input | NUM_FAULTS | Fault condition levels, index 0 is the shared fault |
| retry_ticks | input | CNT_W | Retry interval in ticks |
| restart_ticks | input | CNT_W | Minimum RUN-low hold in ticks |
| dis_req | output | 1 | Disable request to the power stage |
| run_pull_low | output | 1 | Pull-down request for the RUN line |
| fault_pin | output | 1 | Fault pin assert |
| start_req | output | 1 | Pulse: retry start request |
| fault_hit | output | NUM_FAULTS | Pulse per fault on its rising edge |

## Verification
The embedded assertions check these properties on every cycle:
- A rejected write never alters the stored responses.
- A delay counter is zero after a cycle with its fault inactive.
- A held RUN line keeps the channel disabled.
- A retry start always ends a fault-pin period.
- A latched channel stays latched while enabled.
- Hit pulses never last two cycles.

The directed scenarios cover behaviour that depends on timing:
- Tick-count windows for delayed shutdown, retry and restart hold.
- Cancellation and restart of the delay.
- The off/on toggle that clears a latch.
- Encodings that are refused.
- Arbitration between faults that trip together.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [1:0] {
    ACT_IGNORE = 2'b00,
    ACT_DELAY  = 2'b01,
    ACT_STOP   = 2'b10,
    ACT_HOLD   = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    CH_OFF,
    CH_RUN,
    CH_LATCH,
    CH_WAIT
  } ch_state_e;

  localparam logic [2:0] RETRY_LATCH   = 3'b000;
  localparam logic [2:0] RETRY_FOREVER = 3'b111;
  localparam logic [7:0] SHARED_TRIST  = 8'hC0;

  function automatic logic resp_legal(input logic [7:0] b, input logic shared);
    logic ok;
    if (shared) begin
      ok = (b == 8'h00) || (b == SHARED_TRIST);
    end else begin
      ok = (b[7:6] != ACT_HOLD) &&
           ((b[5:3] == RETRY_LATCH) || (b[5:3] == RETRY_FOREVER));
    end
    return ok;
  endfunction

endpackage

// File: rtl/frs_tick_gen.sv
module frs_tick_gen #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == TW'(TICK_DIV - 1));

  always_comb begin
    if (tick_o) cnt_d = '0;
    else        cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frs_resp_regs.sv
module frs_resp_regs
  import frs_pkg::*;
#(
  parameter int NUM_FAULTS = 4,
  parameter int SHARED_IDX = 0,
  localparam int SEL_W     = $clog2(NUM_FAULTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [7:0]                 data_i,
  output logic [NUM_FAULTS-1:0][7:0] resp_o,
  output logic                       reject_o
);
  logic [NUM_FAULTS-1:0][7:0] resp_q, resp_d;
  logic                       reject_q, reject_d;
  logic                       in_range, legal, upd;

  assign in_range = ({1'b0, sel_i} < (SEL_W+1)'(NUM_FAULTS));
  assign legal    = resp_legal(data_i, sel_i == SEL_W'(SHARED_IDX));
  assign upd      = we_i && in_range && legal;

  always_comb begin
    resp_d = resp_q;
    if (upd) resp_d[sel_i] = data_i;
    reject_d = we_i && !(in_range && legal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q   <= '0;
      reject_q <= 1'b0;
    end else begin
      resp_q   <= resp_d;
      reject_q <= reject_d;
    end
  end

  assign resp_o   = resp_q;
  assign reject_o = reject_q;

  p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |-> $stable(resp_q));
endmodule

// File: rtl/frs_fault_eval.sv
module frs_fault_eval
  import frs_pkg::*;
#(
  parameter bit IS_SHARED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       active_i,
  input  logic       evt_i,
  input  act_e       act_i,
  input  logic [2:0] dly_i,
  output logic       trip_o,
  output logic       hold_o
);
  logic [2:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!active_i || !evt_i || act_i != ACT_DELAY) begin
      cnt_d = '0;
    end else if (tick_i && cnt_q < dly_i) begin
      cnt_d = cnt_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trip_o = !IS_SHARED && active_i && evt_i &&
                  ((act_i == ACT_STOP) || (act_i == ACT_DELAY && cnt_q >= dly_i));
  assign hold_o = IS_SHARED && evt_i && (act_i == ACT_HOLD);

  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> (cnt_q == 3'd0));
endmodule

// File: rtl/frs_run_hold.sv
module frs_run_hold #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             pull_o
);
  logic             run_q;
  logic             hold_q, hold_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fall;

  assign fall = run_q && !run_i;

  always_comb begin
    hold_d = hold_q;
    cnt_d  = cnt_q;
    if (fall) begin
      hold_d = 1'b1;
      cnt_d  = '0;
    end else if (hold_q) begin
      if (cnt_q >= limit_i)  hold_d = 1'b0;
      else if (tick_i)       cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_i;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pull_o = hold_q;

  p_fall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> hold_q);
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl
  import frs_pkg::*;
#(
  parameter int NUM_FAULTS = 4,
  parameter int SHARED_IDX = 0,
  parameter int TICK_DIV   = 50000,
  parameter int CNT_W      = 16,
  localparam int SEL_W     = $clog2(NUM_FAULTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SEL_W-1:0]      cfg_sel,
  input  logic [7:0]            cfg_data,
  output logic                  cfg_reject,
  input  logic                  run_in,
  input  logic                  op_on,
  input  logic [NUM_FAULTS-1:0] fault_evt,
  input  logic [CNT_W-1:0]      retry_ticks,
  input  logic [CNT_W-1:0]      restart_ticks,
  output logic                  dis_req,
  output logic                  run_pull_low,
  output logic                  fault_pin,
  output logic                  start_req,
  output logic [NUM_FAULTS-1:0] fault_hit
);
  logic                       tick;
  logic [NUM_FAULTS-1:0][7:0] resp;
  logic [NUM_FAULTS-1:0]      trip, hold;
  ch_state_e                  st_q, st_d;
  logic [CNT_W-1:0]           wcnt_q, wcnt_d;
  logic                       start_q, start_d;
  logic [NUM_FAULTS-1:0]      evt_q, hit_q;
  logic                       enable, active, any_trip, sel_forever;

  frs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  frs_resp_regs #(.NUM_FAULTS(NUM_FAULTS), .SHARED_IDX(SHARED_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
    .data_i(cfg_data), .resp_o(resp), .reject_o(cfg_reject)
  );

  frs_run_hold #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run_in),
    .limit_i(restart_ticks), .pull_o(run_pull_low)
  );

  assign enable = run_in && op_on && !run_pull_low;
  assign active = (st_q == CH_RUN);

  for (genvar gi = 0; gi < NUM_FAULTS; gi++) begin : g_eval
    frs_fault_eval #(.IS_SHARED(gi == SHARED_IDX)) u_eval (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .active_i(active),
      .evt_i(fault_evt[gi]), .act_i(act_e'(resp[gi][7:6])),
      .dly_i(resp[gi][2:0]), .trip_o(trip[gi]), .hold_o(hold[gi])
    );
  end

  // lowest index that trips decides the after-shutdown behaviour
  always_comb begin
    any_trip    = |trip;
    sel_forever = 1'b0;
    for (int i = NUM_FAULTS - 1; i >= 0; i--) begin
      if (trip[i]) sel_forever = (resp[i][5:3] == RETRY_FOREVER);
    end
  end

  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    start_d = 1'b0;
    unique case (st_q)
      CH_OFF: if (enable) st_d = CH_RUN;
      CH_RUN: begin
        if (!enable) begin
          st_d = CH_OFF;
        end else if (any_trip) begin
          st_d   = sel_forever ? CH_WAIT : CH_LATCH;
          wcnt_d = '0;
        end
      end
      CH_LATCH: if (!enable) st_d = CH_OFF;
      CH_WAIT: begin
        if (!enable) begin
          st_d = CH_OFF;
        end else if (wcnt_q >= retry_ticks) begin
          st_d    = CH_RUN;
          start_d = 1'b1;
        end else if (tick) begin
          wcnt_d = wcnt_q + CNT_W'(1);
        end
      end
      default: st_d = CH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CH_OFF;
      wcnt_q  <= '0;
      start_q <= 1'b0;
      evt_q   <= '0;
      hit_q   <= '0;
    end else begin
      st_q    <= st_d;
      wcnt_q  <= wcnt_d;
      start_q <= start_d;
      evt_q   <= fault_evt;
      hit_q   <= fault_evt & ~evt_q;
    end
  end

  assign dis_req   = (st_q != CH_RUN) || (|hold);
  assign fault_pin = (st_q == CH_LATCH) || (st_q == CH_WAIT);
  assign start_req = start_q;
  assign fault_hit = hit_q;

  p_pull_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_pull_low && $past(run_pull_low)) |-> dis_req);

  p_start_ends_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (!fault_pin && $past(fault_pin)));

  p_latch_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CH_LATCH) && run_in && op_on && !run_pull_low) |=> fault_pin);

  p_hit_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_hit) |=> ((fault_hit & $past(fault_hit)) == '0));
endmodule

// File: tb/fault_retry_ctrl_tb.sv
module fault_retry_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_sel;
  logic [7:0] cfg_data;
  logic       cfg_reject;
  logic       run_in, op_on;
  logic [3:0] fault_evt;
  logic [7:0] retry_ticks, restart_ticks;
  logic       dis_req, run_pull_low, fault_pin, start_req;
  logic [3:0] fault_hit;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fault_retry_ctrl #(.NUM_FAULTS(4), .SHARED_IDX(0), .TICK_DIV(4), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .cfg_reject(cfg_reject), .run_in(run_in),
    .op_on(op_on), .fault_evt(fault_evt), .retry_ticks(retry_ticks),
    .restart_ticks(restart_ticks), .dis_req(dis_req),
    .run_pull_low(run_pull_low), .fault_pin(fault_pin),
    .start_req(start_req), .fault_hit(fault_hit)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act,
                         input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wcfg(input logic [1:0] s, input logic [7:0] d, output logic rej);
    cfg_sel = s; cfg_data = d; cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
    rej = cfg_reject;
  endtask

  task automatic toggle_op();
    op_on = 1'b0; step(1);
    op_on = 1'b1; step(1);
  endtask

  task automatic t_reset();
    chk("R1", "dis_req", dis_req, 1);
    chk("R1", "run_pull_low", run_pull_low, 0);
    chk("R1", "fault_pin", fault_pin, 0);
    chk("R1", "start_req", start_req, 0);
    chk("R1", "cfg_reject", cfg_reject, 0);
    chk("R1", "fault_hit", fault_hit, 0);
  endtask

  task automatic t_enable();
    run_in = 1'b1; op_on = 1'b1;
    step(1);
    chk("R2", "dis_req after enable", dis_req, 0);
  endtask

  task automatic t_ignore();
    fault_evt[1] = 1'b1;
    step(1);
    chk("R11", "fault_hit pulse", fault_hit, 4'b0010);
    step(1);
    chk("R11", "fault_hit one cycle", fault_hit, 0);
    step(20);
    chk("R3", "dis_req with ignored fault", dis_req, 0);
    chk("R3", "fault_pin with ignored fault", fault_pin, 0);
    fault_evt[1] = 1'b0;
    step(1);
  endtask

  task automatic t_reject();
    logic rej;
    wcfg(2'd1, 8'hC0, rej);
    chk("R8", "reject action 11", rej, 1);
    fault_evt[1] = 1'b1; step(3); fault_evt[1] = 1'b0;
    chk("R8", "byte unchanged so fault ignored", dis_req, 0);
    wcfg(2'd1, 8'h98, rej);
    chk("R8", "reject retry 011", rej, 1);
    wcfg(2'd0, 8'h80, rej);
    chk("R8", "reject shared 0x80", rej, 1);
    wcfg(2'd1, 8'h80, rej);
    chk("R8", "accept 0x80", rej, 0);
  endtask

  task automatic t_latch();
    fault_evt[1] = 1'b1;
    step(1);
    chk("R4", "dis_req after stop", dis_req, 1);
    chk("R4", "fault_pin after stop", fault_pin, 1);
    fault_evt[1] = 1'b0;
    step(30);
    chk("R4", "dis_req latched", dis_req, 1);
    chk("R4", "fault_pin latched", fault_pin, 1);
    op_on = 1'b0; step(1);
    chk("R4", "fault_pin cleared by off", fault_pin, 0);
    op_on = 1'b1; step(1);
    chk("R4", "dis_req after on", dis_req, 0);
  endtask

  task automatic t_retry();
    logic rej;
    int n, starts;
    wcfg(2'd2, 8'hB8, rej);
    chk("R5", "accept 0xB8", rej, 0);
    retry_ticks = 8'd5;
    fault_evt[2] = 1'b1;
    step(1);
    chk("R5", "fault_pin in retry wait", fault_pin, 1);
    fault_evt[2] = 1'b0;
    n = 0;
    while (!start_req && n < 60) begin step(1); n++; end
    chk_rng("R5", "cycles to start_req", n, 16, 24);
    chk("R5", "fault_pin at start", fault_pin, 0);
    chk("R5", "dis_req at start", dis_req, 0);
    fault_evt[2] = 1'b1;
    starts = 0;
    for (int i = 0; i < 80; i++) begin
      step(1);
      if (start_req) starts++;
    end
    chk_rng("R5", "repeated starts", starts, 2, 5);
    fault_evt[2] = 1'b0;
    n = 0;
    while (dis_req && n < 40) begin step(1); n++; end
    chk("R5", "running after fault gone", dis_req, 0);
  endtask

  task automatic t_delay();
    logic rej;
    int n;
    wcfg(2'd3, 8'h43, rej);
    chk("R6", "accept 0x43", rej, 0);
    fault_evt[3] = 1'b1;
    n = 0;
    while (!dis_req && n < 40) begin step(1); n++; end
    chk_rng("R6", "cycles to delayed stop", n, 8, 14);
    chk("R6", "fault_pin after delayed stop", fault_pin, 1);
    fault_evt[3] = 1'b0;
    toggle_op();
  endtask

  task automatic t_cancel();
    int n;
    fault_evt[3] = 1'b1; step(5);
    fault_evt[3] = 1'b0; step(30);
    chk("R7", "short fault cancelled", dis_req, 0);
    fault_evt[3] = 1'b1; step(7);
    chk("R7", "delay restarted from zero", dis_req, 0);
    n = 0;
    while (!dis_req && n < 40) begin step(1); n++; end
    chk("R7", "trip after full delay", dis_req, 1);
    fault_evt[3] = 1'b0;
    toggle_op();
  endtask

  task automatic t_shared();
    logic rej;
    fault_evt[0] = 1'b1; step(3);
    chk("R10", "shared 0x00 ignored", dis_req, 0);
    wcfg(2'd0, 8'hC0, rej);
    chk("R10", "accept shared 0xC0", rej, 0);
    step(1);
    chk("R10", "dis_req while shared low", dis_req, 1);
    chk("R10", "no fault_pin for shared", fault_pin, 0);
    fault_evt[0] = 1'b0; step(1);
    chk("R10", "dis_req released", dis_req, 0);
  endtask

  task automatic t_priority();
    int starts;
    fault_evt[1] = 1'b1; fault_evt[2] = 1'b1;
    step(1);
    fault_evt[1] = 1'b0; fault_evt[2] = 1'b0;
    starts = 0;
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (start_req) starts++;
    end
    chk("R12", "lowest index latches, no retry", starts, 0);
    chk("R12", "fault_pin held", fault_pin, 1);
    toggle_op();
    chk("R12", "cleared", dis_req, 0);
  endtask

  task automatic t_runhold();
    int n;
    restart_ticks = 8'd6;
    run_in = 1'b0; step(1);
    chk("R9", "pull low after fall", run_pull_low, 1);
    run_in = 1'b1; step(10);
    chk("R9", "still disabled in hold", dis_req, 1);
    n = 11;
    while (dis_req && n < 60) begin step(1); n++; end
    chk_rng("R9", "cycles until running", n, 20, 30);
    chk("R9", "pull released", run_pull_low, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
    run_in = 1'b0; op_on = 1'b0; fault_evt = '0;
    retry_ticks = 8'd5; restart_ticks = 8'd6;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_enable();
    t_ignore();
    t_reject();
    t_latch();
    t_retry();
    t_delay();
    t_cancel();
    t_shared();
    t_priority();
    t_runhold();
    summary();
  end
endmodule